// File: doc/BRIEF.md
# Image resize parameter calculator

This block turns a pair of source and destination dimensions, one pair for the vertical axis and one for the horizontal axis, into a single 32-bit scaler configuration word. For each axis it first picks a power-of-two pre-decimation exponent (zero, one or two halvings). It then computes a 14-bit fixed-point step with 13 fractional bits. The step is the ratio of the reduced source size minus one to the destination size minus one.

A request is launched with a one-cycle `start` pulse while the block is idle. The four sizes are captured on that edge. The sizes are range-checked first. If both axes are legal, one shared restoring divider is run twice, vertical axis first and then horizontal, producing one quotient bit per cycle. The block then raises `done` for one cycle. At that point `cfg_word`, `err` and `warn` are valid, and they hold their values until the next `done`.

Top module: `rsz_calc`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `warn` are 0 and `cfg_word` is 0.
- R2: A source size of 0 or above 4096 on either axis makes the request fail: `err`=1, `warn`=0, `cfg_word`=0 at `done`.
- R3: A destination size below 2 or above 1024 on either axis makes the request fail in the same way as R2.
- R4: A destination size whose fourfold value is less than the source size (reduction steeper than 4:1) makes the request fail in the same way as R2.
- R5: Per axis, the working size starts at the source size. It is halved (integer division by 2) and the exponent is incremented while the working size is above 1024 or at least twice the destination size. Halving stops once the exponent is 2, so the exponent is 0, 1 or 2.
- R6: Per axis, step = floor(8192 × (working size − 1) / (destination size − 1)) when that value is below 16384.
- R7: If the value in R6 is 16384 or more, the step is 0x3FFF and `warn` is 1 at `done`. `warn` is 0 when neither axis saturates.
- R8: `cfg_word` is laid out as: bits [31:30] vertical exponent, [29:16] vertical step, [15:14] horizontal exponent, [13:0] horizontal step. `err` is 0 on success.
- R9: `done` is high for exactly one cycle per accepted request, and `busy` is low in that cycle.
- R10: A `start` pulse while `busy` is high is ignored: the running request completes with results for its own captured sizes, and no extra `done` follows.
- R11: A `start` pulse while idle makes `busy` high from the next cycle until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when idle |
| src_v | input | 13 | Vertical source size |
| dst_v | input | 11 | Vertical destination size |
| src_h | input | 13 | Horizontal source size |
| dst_h | input | 11 | Horizontal destination size |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected by a size limit |
| warn | output | 1 | A step saturated at 0x3FFF |
| cfg_word | output | 32 | Packed exponents and steps |

## Verification
A corrupted remainder or a miscounted divider step shows up as a wrong 14-bit step field at the very next `done`, roughly sixty cycles after `start`. A stale axis select or exponent register shows up as swapped or mismatched fields within the same word. A sequencing fault in the controller is exposed as a missing or doubled `done` pulse, or as `busy` held high past completion. Random legal sizes compared against an independent model cover the arithmetic. Directed limit and saturation cases cover the error and clamp paths.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RUN
  } rsz_state_e;

  localparam int AXIS_V = 0;
  localparam int AXIS_H = 1;
  localparam int N_AXES = 2;
endpackage

// File: rtl/rsz_limit_check.sv
module rsz_limit_check #(
  parameter int IN_W    = 13,
  parameter int OUT_W   = 11,
  parameter int IN_MAX  = 4096,
  parameter int OUT_MAX = 1024
) (
  input  logic [IN_W-1:0]  src_sz,
  input  logic [OUT_W-1:0] dst_sz,
  output logic             bad
);
  logic [IN_W+1:0] dst_x4;
  logic [IN_W+1:0] src_ext;

  assign dst_x4  = {{(IN_W-OUT_W){1'b0}}, dst_sz, 2'b00};
  assign src_ext = {2'b00, src_sz};

  always_comb begin
    bad = 1'b0;
    if (src_sz == '0) bad = 1'b1;
    if (32'(src_sz) > IN_MAX) bad = 1'b1;
    if (32'(dst_sz) > OUT_MAX) bad = 1'b1;
    if (dst_sz < OUT_W'(2)) bad = 1'b1;
    if (dst_x4 < src_ext) bad = 1'b1;
  end
endmodule

// File: rtl/rsz_predecim.sv
module rsz_predecim #(
  parameter int IN_W    = 13,
  parameter int OUT_W   = 11,
  parameter int OUT_MAX = 1024,
  parameter int MAX_DEC = 2,
  localparam int DEC_W  = $clog2(MAX_DEC + 1)
) (
  input  logic [IN_W-1:0]  src_sz,
  input  logic [OUT_W-1:0] dst_sz,
  output logic [IN_W-1:0]  work_sz,
  output logic [DEC_W-1:0] dec_exp
);
  logic [IN_W:0] dst_x2;
  assign dst_x2 = {{(IN_W-OUT_W){1'b0}}, dst_sz, 1'b0};

  always_comb begin
    work_sz = src_sz;
    dec_exp = '0;
    for (int i = 0; i < MAX_DEC; i++) begin
      if ((32'(work_sz) > OUT_MAX) || ({1'b0, work_sz} >= dst_x2)) begin
        work_sz = work_sz >> 1;
        dec_exp = dec_exp + DEC_W'(1);
      end
    end
  end
endmodule

// File: rtl/rsz_divider.sv
module rsz_divider #(
  parameter int DVD_W = 26,
  parameter int DVS_W = 11,
  localparam int CNT_W = $clog2(DVD_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             fin,
  output logic [DVD_W-1:0] quot
);
  logic [DVS_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [DVD_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DVS_W:0]   trial;
  logic             take;

  assign trial = {rem_q, sh_q[DVD_W-1]};
  assign take  = trial >= {1'b0, dvs_q};
  assign quot  = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dvs_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (go) begin
          rem_q <= '0;
          dvs_q <= divisor;
          sh_q  <= dividend;
          cnt_q <= CNT_W'(DVD_W);
          busy  <= 1'b1;
        end
      end else begin
        rem_q <= take ? (trial[DVS_W-1:0] - dvs_q) : trial[DVS_W-1:0];
        sh_q  <= {sh_q[DVD_W-2:0], take};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsz_calc.sv
module rsz_calc
  import rsz_pkg::*;
#(
  parameter int IN_W    = 13,
  parameter int OUT_W   = 11,
  parameter int FRAC_W  = 13,
  parameter int STEP_W  = 14,
  parameter int IN_MAX  = 4096,
  parameter int OUT_MAX = 1024,
  parameter int MAX_DEC = 2,
  localparam int DEC_W  = $clog2(MAX_DEC + 1),
  localparam int DVD_W  = IN_W + FRAC_W,
  localparam int WORD_W = 2 * (DEC_W + STEP_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IN_W-1:0]   src_v,
  input  logic [OUT_W-1:0]  dst_v,
  input  logic [IN_W-1:0]   src_h,
  input  logic [OUT_W-1:0]  dst_h,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              warn,
  output logic [WORD_W-1:0] cfg_word
);
  rsz_state_e state_q;

  logic [IN_W-1:0]  src_q [N_AXES];
  logic [OUT_W-1:0] dst_q [N_AXES];
  logic [IN_W-1:0]  work  [N_AXES];
  logic [DEC_W-1:0] dexp  [N_AXES];
  logic [N_AXES-1:0] bad;

  logic              axis_q;
  logic              go_q;
  logic [DEC_W-1:0]  dec_v_q;
  logic [STEP_W-1:0] step_v_q;
  logic              warn_v_q;

  logic [IN_W-1:0]   work_sel;
  logic [OUT_W-1:0]  dst_sel;
  logic [DVD_W-1:0]  dvd;
  logic [OUT_W-1:0]  dvs;
  logic              div_busy;
  logic              div_fin;
  logic [DVD_W-1:0]  div_q;
  logic              ovf;
  logic [STEP_W-1:0] step;

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    rsz_limit_check #(
      .IN_W(IN_W), .OUT_W(OUT_W), .IN_MAX(IN_MAX), .OUT_MAX(OUT_MAX)
    ) u_lim (
      .src_sz(src_q[a]), .dst_sz(dst_q[a]), .bad(bad[a])
    );
    rsz_predecim #(
      .IN_W(IN_W), .OUT_W(OUT_W), .OUT_MAX(OUT_MAX), .MAX_DEC(MAX_DEC)
    ) u_dec (
      .src_sz(src_q[a]), .dst_sz(dst_q[a]), .work_sz(work[a]), .dec_exp(dexp[a])
    );
  end

  assign work_sel = axis_q ? work[AXIS_H] : work[AXIS_V];
  assign dst_sel  = axis_q ? dst_q[AXIS_H] : dst_q[AXIS_V];
  assign dvd      = {work_sel - IN_W'(1), {FRAC_W{1'b0}}};
  assign dvs      = dst_sel - OUT_W'(1);

  rsz_divider #(.DVD_W(DVD_W), .DVS_W(OUT_W)) u_div (
    .clk(clk), .rst(rst), .go(go_q), .dividend(dvd), .divisor(dvs),
    .busy(div_busy), .fin(div_fin), .quot(div_q)
  );

  assign ovf  = |div_q[DVD_W-1:STEP_W];
  assign step = ovf ? {STEP_W{1'b1}} : div_q[STEP_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      for (int a = 0; a < N_AXES; a++) begin
        src_q[a] <= '0;
        dst_q[a] <= '0;
      end
      axis_q   <= 1'b0;
      go_q     <= 1'b0;
      dec_v_q  <= '0;
      step_v_q <= '0;
      warn_v_q <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      warn     <= 1'b0;
      cfg_word <= '0;
    end else begin
      done <= 1'b0;
      go_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            src_q[AXIS_V] <= src_v;
            dst_q[AXIS_V] <= dst_v;
            src_q[AXIS_H] <= src_h;
            dst_q[AXIS_H] <= dst_h;
            busy    <= 1'b1;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (|bad) begin
            err      <= 1'b1;
            warn     <= 1'b0;
            cfg_word <= '0;
            done     <= 1'b1;
            busy     <= 1'b0;
            state_q  <= ST_IDLE;
          end else begin
            axis_q  <= 1'b0;
            go_q    <= 1'b1;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (div_fin) begin
            if (!axis_q) begin
              dec_v_q  <= dexp[AXIS_V];
              step_v_q <= step;
              warn_v_q <= ovf;
              axis_q   <= 1'b1;
              go_q     <= 1'b1;
            end else begin
              cfg_word <= {dec_v_q, step_v_q, dexp[AXIS_H], step};
              warn     <= warn_v_q | ovf;
              err      <= 1'b0;
              done     <= 1'b1;
              busy     <= 1'b0;
              state_q  <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsz_calc_chk.sv
module rsz_calc_chk #(
  parameter int STEP_W = 14,
  parameter int DEC_W  = 2,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              warn,
  input logic [WORD_W-1:0] cfg_word
);
  localparam int H_STEP_LO = 0;
  localparam int H_DEC_LO  = STEP_W;
  localparam int V_STEP_LO = STEP_W + DEC_W;
  localparam int V_DEC_LO  = 2 * STEP_W + DEC_W;
  localparam logic [STEP_W-1:0] SAT = {STEP_W{1'b1}};

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !done) |=> busy); // R11
  AST_ERR_CLEARS_WORD: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (cfg_word == '0 && !warn)); // R2
  AST_WARN_HAS_SAT: assert property (@(posedge clk) disable iff (rst)
    (done && warn) |-> (cfg_word[V_STEP_LO +: STEP_W] == SAT ||
                        cfg_word[H_STEP_LO +: STEP_W] == SAT)); // R7
  AST_DEC_BOUND: assert property (@(posedge clk) disable iff (rst)
    done |-> (cfg_word[V_DEC_LO +: DEC_W] != '1 &&
              cfg_word[H_DEC_LO +: DEC_W] != '1)); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(done) && $past(busy)) |-> !done || !busy); // R10
endmodule

bind rsz_calc rsz_calc_chk #(
  .STEP_W(STEP_W), .DEC_W(DEC_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .err(err), .warn(warn), .cfg_word(cfg_word)
);

// File: tb/rsz_calc_tb.sv
module rsz_calc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [12:0] src_v = '0, src_h = '0;
  logic [10:0] dst_v = '0, dst_h = '0;
  logic        busy, done, err, warn;
  logic [31:0] cfg_word;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsz_calc u_dut (
    .clk(clk), .rst(rst), .start(start),
    .src_v(src_v), .dst_v(dst_v), .src_h(src_h), .dst_h(dst_h),
    .busy(busy), .done(done), .err(err), .warn(warn), .cfg_word(cfg_word)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void ref_axis(input int s, input int d, output bit e,
                                   output int dx, output int st, output bit w);
    int t;
    longint q;
    e  = (s == 0) || (s > 4096) || (d < 2) || (d > 1024) || (d * 4 < s);
    dx = 0; st = 0; w = 0;
    if (!e) begin
      t = s;
      while (((t > 1024) || (t >= 2 * d)) && dx < 2) begin
        t = t / 2;
        dx++;
      end
      q  = (64'(8192) * longint'(t - 1)) / longint'(d - 1);
      w  = (q >= 16384);
      st = w ? 16383 : int'(q);
    end
  endfunction

  task automatic run(input int sv, input int dv, input int sh, input int dh,
                     input string tag, input bit poke);
    bit ev, eh, wv, wh, xe, xw;
    int xv, sv2, xh, sh2;
    logic [31:0] xword;
    int n;
    ref_axis(sv, dv, ev, xv, sv2, wv);
    ref_axis(sh, dh, eh, xh, sh2, wh);
    xe = ev | eh;
    xw = xe ? 1'b0 : (wv | wh);
    xword = xe ? 32'd0 : {2'(xv), 14'(sv2), 2'(xh), 14'(sh2)};
    @(negedge clk);
    src_v = 13'(sv); dst_v = 11'(dv); src_h = 13'(sh); dst_h = 11'(dh);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R11 busy"}, 64'(busy), 64'd1);
    n = 0;
    while (!done && n < 400) begin
      if (poke && n == 6) begin
        src_v = 13'd100; dst_v = 11'd77; src_h = 13'd33; dst_h = 11'd9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end else begin
        @(negedge clk);
      end
      n++;
    end
    chk({tag, " R9 done seen"}, 64'(done), 64'd1);
    chk({tag, " R9 busy low at done"}, 64'(busy), 64'd0);
    chk({tag, " err"}, 64'(err), 64'(xe));
    chk({tag, " warn"}, 64'(warn), 64'(xw));
    chk({tag, " word"}, 64'(cfg_word), 64'(xword));
    @(negedge clk);
    chk({tag, " R9 single pulse"}, 64'(done), 64'd0);
    if (poke) begin
      repeat (80) begin
        @(negedge clk);
        if (done) chk({tag, " R10 no extra done"}, 64'd1, 64'd0);
      end
      chk({tag, " R10 idle after"}, 64'(busy), 64'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 err", 64'(err), 0);
    chk("R1 warn", 64'(warn), 0);
    chk("R1 word", 64'(cfg_word), 0);

    run(4097, 1024, 100, 50, "R2 src over", 0);
    run(0, 10, 100, 50, "R2 src zero", 0);
    run(100, 50, 100, 1025, "R3 dst over", 0);
    run(100, 50, 2, 1, "R3 dst one", 0);
    run(9, 2, 100, 50, "R4 steep", 0);
    run(8, 2, 4096, 1024, "R5 two halvings", 0);
    run(2000, 1000, 1500, 1024, "R5 size limit halving", 0);
    run(3, 2, 640, 480, "R7 clamp", 0);
    run(480, 640, 5, 3, "R7 clamp horiz", 0);
    run(720, 480, 1280, 720, "R6 R8 layout", 0);
    run(1000, 300, 200, 64, "R10 start ignored", 1);

    for (int k = 0; k < 300; k++) begin
      int dv, dh, sv, sh, hv, hh;
      dv = 2 + int'($urandom % 1023);
      dh = 2 + int'($urandom % 1023);
      hv = (4 * dv > 4096) ? 4096 : 4 * dv;
      hh = (4 * dh > 4096) ? 4096 : 4 * dh;
      sv = 1 + int'($urandom % hv);
      sh = 1 + int'($urandom % hh);
      if (k % 10 == 9) begin
        sv = int'($urandom % 5000);
        dv = int'($urandom % 1100);
      end
      run(sv, dv, sh, dh, "R6 R8 random", 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule